// File: doc/BRIEF.md
# Erase-Before-Write Page Translation Controller

This block sits in front of a flash array model and gives its user a simple page store: logical pages are read and written by number, and the controller decides where each one lives physically. Flash can only program a page whose block has been erased as a whole, so a logical page can never be overwritten where it stands. The first write into a group of logical pages claims an erased block. Later first-time writes into that group program the matching slot of the same block. Rewriting a page that already holds data moves the whole group: a fresh block is erased, every other valid page is copied into it, the new data is programmed, and the old block goes back to the free pool.

Each physical block carries an erase counter. When a block is chosen, the controller picks the free, unworn block with the lowest count, which spreads wear across the array. A block whose counter has reached the endurance limit is worn out and is never handed out again. A write that needs a block when none is left is refused with an error, and the existing data stays as it was. Erasing is modelled as much slower than programming or reading, so rewrites cost far more cycles than in-place writes.

A logical page number splits into a group index (upper bits) and a slot index (lower bits, one slot per page of a block). A group maps onto one physical block at a time, and a page keeps its slot across moves. Pages per block, block count and logical page count must be powers of two, with at least two groups.

Top module: `ftl_top`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, and every logical page is unmapped.
- R2: A read of an unmapped logical page answers with rsp_rdata all ones, rsp_err 0 and rsp_phys 0.
- R3: A first write to a page whose group already owns a block programs that block in place. rsp_err is 0, rsp_phys names that block, and no erase takes place.
- R4: A read of a mapped page returns the data most recently written to it, with rsp_err 0 and rsp_phys equal to the block that currently holds the group.
- R5: A write to a page that already holds data moves its group to a freshly erased block. Every other valid page of the group keeps its data, and pages that were never written stay unmapped.
- R6: A page is programmed only while it is still erased since its block's last erase. A write that needs a new block therefore answers no sooner than ERASE_CYC cycles after acceptance, and an in-place write answers sooner than that.
- R7: A new block is the free block (owned by no group) with the lowest erase count, with ties going to the lowest block index. rsp_phys reports it.
- R8: Each erase adds one to its block's counter. A block whose counter has reached WEAR_LIMIT is never erased or allocated again.
- R9: A write that needs a new block when none is free and unworn answers with rsp_err 1 and rsp_phys 0. The mapping and the stored data of every page stay unchanged.
- R10: Each accepted request gets exactly one single-cycle response. req_ready is 0 while a flash operation is in progress, and responses appear only when the controller is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; taken when req_ready is 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_lpage | input | $clog2(LPAGES) | Logical page number (upper bits group, lower bits slot) |
| req_wdata | input | DW | Data to write |
| req_ready | output | 1 | Controller idle and able to take a request |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Write refused for lack of a free unworn block |
| rsp_rdata | output | DW | Read data (all ones for unmapped pages) |
| rsp_phys | output | $clog2(NUM_BLKS) | Physical block holding the page, 0 when none |

## Verification
The bench uses a configuration of four blocks of four pages, eight logical pages in two groups, and a wear limit of three. It first reads every page while unmapped, then writes a single page and rewrites it while a neighbour in the group holds data and two slots are still empty. This tells a correct copy apart from one that drops or invents pages. A fill of all slots then separates in-place programming from allocation, both by the block reported and by latency. A long run of rewrites that alternates between the groups drains the blocks' endurance. It exposes errors in least-worn selection and tie-breaking, in retirement of worn blocks, and in the refusal path, with every page read back against an arithmetic model after each write.

// File: rtl/ftl_pkg.sv
package ftl_pkg;
  typedef enum logic [1:0] {
    FOP_READ  = 2'd0,
    FOP_PROG  = 2'd1,
    FOP_ERASE = 2'd2
  } flash_op_e;
endpackage

// File: rtl/ftl_flash_model.sv
module ftl_flash_model
  import ftl_pkg::*;
#(
  parameter int NUM_BLKS  = 8,
  parameter int PPB       = 32,
  parameter int DW        = 16,
  parameter int ERASE_CYC = 64,
  parameter int PROG_CYC  = 8,
  parameter int READ_CYC  = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cmd_valid,
  input  flash_op_e                   cmd_op,
  input  logic [$clog2(NUM_BLKS)-1:0] cmd_blk,
  input  logic [$clog2(PPB)-1:0]      cmd_pg,
  input  logic [DW-1:0]               cmd_wdata,
  output logic                        busy,
  output logic                        done,
  output logic [DW-1:0]               rd_data
);
  localparam int BW   = $clog2(NUM_BLKS);
  localparam int PW   = $clog2(PPB);
  localparam int AW   = BW + PW;
  localparam int NPG  = NUM_BLKS * PPB;
  localparam int TMAX = (ERASE_CYC > PROG_CYC) ?
                        ((ERASE_CYC > READ_CYC) ? ERASE_CYC : READ_CYC) :
                        ((PROG_CYC > READ_CYC) ? PROG_CYC : READ_CYC);
  localparam int TW   = $clog2(TMAX + 1);

  logic [DW-1:0]  mem [NPG];
  logic [DW-1:0]  mem_q;
  logic [NPG-1:0] prog_map;
  logic [TW-1:0]  cnt;
  logic           pbit_q;
  logic [AW-1:0]  addr;
  logic           accept;

  assign addr   = {cmd_blk, cmd_pg};
  assign accept = cmd_valid && !busy;

  // array port kept free of reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (accept && cmd_op == FOP_PROG) mem[addr] <= cmd_wdata;
    if (accept && cmd_op == FOP_READ) mem_q <= mem[addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_map <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      cnt      <= '0;
      pbit_q   <= 1'b0;
    end else if (accept) begin
      busy <= 1'b1;
      done <= 1'b0;
      case (cmd_op)
        FOP_READ: begin
          pbit_q <= prog_map[addr];
          cnt    <= TW'(READ_CYC - 1);
        end
        FOP_PROG: begin
          prog_map[addr] <= 1'b1;
          cnt            <= TW'(PROG_CYC - 1);
        end
        default: begin
          for (int p = 0; p < PPB; p++) prog_map[{cmd_blk, PW'(p)}] <= 1'b0;
          cnt <= TW'(ERASE_CYC - 1);
        end
      endcase
    end else if (busy) begin
      if (cnt == '0) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end

  assign rd_data = pbit_q ? mem_q : '1;

  // R6: the controller programs only pages erased since their last erase
  a_r6_prog_only_erased: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == FOP_PROG) |-> !prog_map[addr]);

  // R6: completion is only signalled at the end of a busy period
  a_r6_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));
endmodule

// File: rtl/ftl_wear_alloc.sv
module ftl_wear_alloc #(
  parameter int NUM_BLKS   = 8,
  parameter int WEAR_LIMIT = 100000
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_BLKS-1:0]         in_use,
  input  logic                        erase_en,
  input  logic [$clog2(NUM_BLKS)-1:0] erase_blk,
  output logic                        pick_valid,
  output logic [$clog2(NUM_BLKS)-1:0] pick_blk
);
  localparam int BW = $clog2(NUM_BLKS);
  localparam int CW = $clog2(WEAR_LIMIT + 1);

  logic [CW-1:0]       ecnt [NUM_BLKS];
  logic [NUM_BLKS-1:0] worn;

  for (genvar gi = 0; gi < NUM_BLKS; gi++) begin : g_blk
    assign worn[gi] = (ecnt[gi] >= CW'(WEAR_LIMIT));
    always_ff @(posedge clk) begin
      if (rst) ecnt[gi] <= '0;
      else if (erase_en && erase_blk == BW'(gi) && !worn[gi]) ecnt[gi] <= ecnt[gi] + 1'b1;
    end
  end

  // least-worn free block, lowest index wins a tie
  always_comb begin
    logic [CW-1:0] best;
    best       = '0;
    pick_valid = 1'b0;
    pick_blk   = '0;
    for (int b = 0; b < NUM_BLKS; b++) begin
      if (!in_use[b] && !worn[b] && (!pick_valid || ecnt[b] < best)) begin
        pick_valid = 1'b1;
        pick_blk   = BW'(b);
        best       = ecnt[b];
      end
    end
  end

  // R8: a worn block is never erased again
  a_r8_erase_unworn: assert property (@(posedge clk) disable iff (rst)
    erase_en |-> !worn[erase_blk]);

  // R8: an erase raises the chosen block's count by one
  a_r8_count_step: assert property (@(posedge clk) disable iff (rst)
    erase_en |=> ecnt[$past(erase_blk)] == $past(ecnt[erase_blk]) + 1'b1);
endmodule

// File: rtl/ftl_ctrl.sv
module ftl_ctrl
  import ftl_pkg::*;
#(
  parameter int NUM_BLKS = 8,
  parameter int PPB      = 32,
  parameter int LPAGES   = 128,
  parameter int DW       = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  input  logic                        req_write,
  input  logic [$clog2(LPAGES)-1:0]   req_lpage,
  input  logic [DW-1:0]               req_wdata,
  output logic                        req_ready,
  output logic                        rsp_valid,
  output logic                        rsp_err,
  output logic [DW-1:0]               rsp_rdata,
  output logic [$clog2(NUM_BLKS)-1:0] rsp_phys,
  output logic                        cmd_valid,
  output flash_op_e                   cmd_op,
  output logic [$clog2(NUM_BLKS)-1:0] cmd_blk,
  output logic [$clog2(PPB)-1:0]      cmd_pg,
  output logic [DW-1:0]               cmd_wdata,
  input  logic                        f_busy,
  input  logic                        f_done,
  input  logic [DW-1:0]               f_rdata,
  output logic [NUM_BLKS-1:0]         in_use,
  output logic                        erase_en,
  output logic [$clog2(NUM_BLKS)-1:0] erase_blk,
  input  logic                        pick_valid,
  input  logic [$clog2(NUM_BLKS)-1:0] pick_blk
);
  localparam int BW   = $clog2(NUM_BLKS);
  localparam int PW   = $clog2(PPB);
  localparam int LW   = $clog2(LPAGES);
  localparam int GW   = LW - PW;
  localparam int NGRP = LPAGES / PPB;
  localparam int CIW  = $clog2(PPB + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_ER_ISS, S_ER_WAIT, S_CP_CHK, S_CR_ISS, S_CR_WAIT,
    S_CP_ISS, S_CP_WAIT, S_PR_ISS, S_PR_WAIT, S_RD_ISS, S_RD_WAIT
  } st_e;

  st_e             st;
  logic [LW-1:0]   lp_q;
  logic [DW-1:0]   wdat_q;
  logic [DW-1:0]   cp_buf;
  logic [BW-1:0]   new_blk;
  logic [BW-1:0]   old_blk;
  logic            moving;
  logic [CIW-1:0]  cp_idx;
  logic [NGRP-1:0] grp_bound;
  logic [BW-1:0]   grp_blk [NGRP];
  logic [LPAGES-1:0] lvalid;

  logic [GW-1:0] grp_q, req_grp;
  logic [PW-1:0] off_q, cp_slot;

  assign grp_q   = lp_q[LW-1:PW];
  assign off_q   = lp_q[PW-1:0];
  assign req_grp = req_lpage[LW-1:PW];
  assign cp_slot = cp_idx[PW-1:0];

  always_comb begin
    in_use = '0;
    for (int b = 0; b < NUM_BLKS; b++)
      for (int g = 0; g < NGRP; g++)
        if (grp_bound[g] && grp_blk[g] == BW'(b)) in_use[b] = 1'b1;
  end

  assign req_ready = (st == S_IDLE);
  assign cmd_valid = (st == S_ER_ISS) || (st == S_CR_ISS) || (st == S_CP_ISS) ||
                     (st == S_PR_ISS) || (st == S_RD_ISS);
  assign erase_en  = (st == S_ER_ISS);
  assign erase_blk = new_blk;

  always_comb begin
    cmd_op    = FOP_READ;
    cmd_blk   = new_blk;
    cmd_pg    = off_q;
    cmd_wdata = wdat_q;
    case (st)
      S_ER_ISS: cmd_op = FOP_ERASE;
      S_CR_ISS: begin cmd_blk = old_blk; cmd_pg = cp_slot; end
      S_CP_ISS: begin cmd_op = FOP_PROG; cmd_pg = cp_slot; cmd_wdata = cp_buf; end
      S_PR_ISS: cmd_op = FOP_PROG;
      S_RD_ISS: cmd_blk = grp_blk[grp_q];
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      lp_q      <= '0;
      wdat_q    <= '0;
      cp_buf    <= '0;
      new_blk   <= '0;
      old_blk   <= '0;
      moving    <= 1'b0;
      cp_idx    <= '0;
      grp_bound <= '0;
      for (int g = 0; g < NGRP; g++) grp_blk[g] <= '0;
      lvalid    <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
      rsp_phys  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          lp_q   <= req_lpage;
          wdat_q <= req_wdata;
          if (!req_write) begin
            if (lvalid[req_lpage]) st <= S_RD_ISS;
            else begin
              rsp_valid <= 1'b1; rsp_err <= 1'b0; rsp_rdata <= '1; rsp_phys <= '0;
            end
          end else if (grp_bound[req_grp] && !lvalid[req_lpage]) begin
            new_blk <= grp_blk[req_grp];
            st      <= S_PR_ISS;
          end else if (pick_valid) begin
            new_blk <= pick_blk;
            old_blk <= grp_blk[req_grp];
            moving  <= grp_bound[req_grp];
            st      <= S_ER_ISS;
          end else begin
            rsp_valid <= 1'b1; rsp_err <= 1'b1; rsp_rdata <= '1; rsp_phys <= '0;
          end
        end
        S_ER_ISS:  st <= S_ER_WAIT;
        S_ER_WAIT: if (f_done) begin
          cp_idx <= '0;
          st     <= moving ? S_CP_CHK : S_PR_ISS;
        end
        S_CP_CHK: begin
          if (cp_idx == CIW'(PPB)) st <= S_PR_ISS;
          else if (cp_slot != off_q && lvalid[{grp_q, cp_slot}]) st <= S_CR_ISS;
          else cp_idx <= cp_idx + 1'b1;
        end
        S_CR_ISS:  st <= S_CR_WAIT;
        S_CR_WAIT: if (f_done) begin
          cp_buf <= f_rdata;
          st     <= S_CP_ISS;
        end
        S_CP_ISS:  st <= S_CP_WAIT;
        S_CP_WAIT: if (f_done) begin
          cp_idx <= cp_idx + 1'b1;
          st     <= S_CP_CHK;
        end
        S_PR_ISS:  st <= S_PR_WAIT;
        S_PR_WAIT: if (f_done) begin
          grp_bound[grp_q] <= 1'b1;
          grp_blk[grp_q]   <= new_blk;
          lvalid[lp_q]     <= 1'b1;
          rsp_valid <= 1'b1; rsp_err <= 1'b0; rsp_rdata <= wdat_q; rsp_phys <= new_blk;
          st        <= S_IDLE;
        end
        S_RD_ISS:  st <= S_RD_WAIT;
        S_RD_WAIT: if (f_done) begin
          rsp_valid <= 1'b1; rsp_err <= 1'b0; rsp_rdata <= f_rdata; rsp_phys <= grp_blk[grp_q];
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R10: commands reach the flash model only when it is free
  a_r10_cmd_when_free: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !f_busy);

  // R10: a response is only produced with the controller back at idle
  a_r10_rsp_at_idle: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> req_ready);

  // R9: a refused write leaves every group binding untouched
  a_r9_err_keeps_map: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> $stable(grp_bound));
endmodule

// File: rtl/ftl_top.sv
module ftl_top
  import ftl_pkg::*;
#(
  parameter int DW         = 16,
  parameter int NUM_BLKS   = 8,
  parameter int PPB        = 32,
  parameter int LPAGES     = 128,
  parameter int WEAR_LIMIT = 100000,
  parameter int ERASE_CYC  = 64,
  parameter int PROG_CYC   = 8,
  parameter int READ_CYC   = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  input  logic                        req_write,
  input  logic [$clog2(LPAGES)-1:0]   req_lpage,
  input  logic [DW-1:0]               req_wdata,
  output logic                        req_ready,
  output logic                        rsp_valid,
  output logic                        rsp_err,
  output logic [DW-1:0]               rsp_rdata,
  output logic [$clog2(NUM_BLKS)-1:0] rsp_phys
);
  localparam int BW = $clog2(NUM_BLKS);
  localparam int PW = $clog2(PPB);

  logic              cmd_valid, f_busy, f_done, erase_en, pick_valid;
  flash_op_e         cmd_op;
  logic [BW-1:0]     cmd_blk, erase_blk, pick_blk;
  logic [PW-1:0]     cmd_pg;
  logic [DW-1:0]     cmd_wdata, f_rdata;
  logic [NUM_BLKS-1:0] in_use;

  ftl_ctrl #(.NUM_BLKS(NUM_BLKS), .PPB(PPB), .LPAGES(LPAGES), .DW(DW)) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_lpage(req_lpage),
    .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .rsp_phys(rsp_phys),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_blk(cmd_blk), .cmd_pg(cmd_pg),
    .cmd_wdata(cmd_wdata), .f_busy(f_busy), .f_done(f_done), .f_rdata(f_rdata),
    .in_use(in_use), .erase_en(erase_en), .erase_blk(erase_blk),
    .pick_valid(pick_valid), .pick_blk(pick_blk)
  );

  ftl_flash_model #(.NUM_BLKS(NUM_BLKS), .PPB(PPB), .DW(DW), .ERASE_CYC(ERASE_CYC),
                    .PROG_CYC(PROG_CYC), .READ_CYC(READ_CYC)) u_flash (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_blk(cmd_blk),
    .cmd_pg(cmd_pg), .cmd_wdata(cmd_wdata), .busy(f_busy), .done(f_done), .rd_data(f_rdata)
  );

  ftl_wear_alloc #(.NUM_BLKS(NUM_BLKS), .WEAR_LIMIT(WEAR_LIMIT)) u_alloc (
    .clk(clk), .rst(rst), .in_use(in_use), .erase_en(erase_en), .erase_blk(erase_blk),
    .pick_valid(pick_valid), .pick_blk(pick_blk)
  );
endmodule

// File: tb/ftl_top_tb.sv
module ftl_top_tb;
  localparam int DW = 8, NB = 4, PPB = 4, LP = 8, LIM = 3;
  localparam int ERASE = 12, PROG = 3, RD = 2;
  localparam int NG = LP / PPB;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [2:0] req_lpage = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err;
  logic [DW-1:0] rsp_rdata;
  logic [1:0] rsp_phys;

  int checks = 0, fails = 0;
  int cnt [NB];
  bit bound [NG];
  int gblk [NG];
  bit valid [LP];
  int data [LP];
  bit err_seen = 0;

  always #10 clk = ~clk;

  ftl_top #(.DW(DW), .NUM_BLKS(NB), .PPB(PPB), .LPAGES(LP), .WEAR_LIMIT(LIM),
            .ERASE_CYC(ERASE), .PROG_CYC(PROG), .READ_CYC(RD)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_lpage(req_lpage), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .rsp_phys(rsp_phys));

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // issue one request and return its latency in cycles
  task automatic issue(bit wr, int l, int d, output int lat);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_lpage = 3'(l); req_wdata = DW'(d);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    if (!rsp_valid) check(req_ready == 1'b0, "R10 busy", int'(req_ready), 0);
    while (!rsp_valid && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
    check(rsp_valid == 1'b1, "R10 response", int'(rsp_valid), 1);
  endtask

  task automatic after_rsp();
    @(negedge clk);
    check(rsp_valid == 1'b0, "R10 single pulse", int'(rsp_valid), 0);
  endtask

  function automatic int pick();
    int p = -1;
    for (int b = 0; b < NB; b++) begin
      bit used = 0;
      for (int g = 0; g < NG; g++) if (bound[g] && gblk[g] == b) used = 1;
      if (!used && cnt[b] < LIM && (p < 0 || cnt[b] < cnt[p])) p = b;
    end
    return p;
  endfunction

  task automatic do_read(int l, string tag);
    int lat;
    int ed = valid[l] ? data[l] : 8'hFF;
    int ep = valid[l] ? gblk[l / PPB] : 0;
    issue(1'b0, l, 0, lat);
    check(int'(rsp_rdata) == ed, valid[l] ? tag : "R2 data", int'(rsp_rdata), ed);
    check(int'(rsp_phys) == ep, valid[l] ? "R4 phys" : "R2 phys", int'(rsp_phys), ep);
    check(rsp_err == 1'b0, "R4 err", int'(rsp_err), 0);
    after_rsp();
  endtask

  task automatic read_all(string tag);
    for (int l = 0; l < LP; l++) do_read(l, tag);
  endtask

  task automatic do_write(int l, int d);
    int lat, p, ep;
    int g = l / PPB;
    bit need_new = !(bound[g] && !valid[l]);
    bit eerr = 0;
    if (!need_new) ep = gblk[g];
    else begin
      p = pick();
      if (p < 0) begin eerr = 1; ep = 0; err_seen = 1; end
      else begin cnt[p]++; gblk[g] = p; bound[g] = 1; ep = p; end
    end
    if (!eerr) begin valid[l] = 1; data[l] = d & 8'hFF; end
    issue(1'b1, l, d, lat);
    check(rsp_err == eerr, "R9 err flag", int'(rsp_err), int'(eerr));
    check(int'(rsp_phys) == ep, need_new ? "R7 R8 block choice" : "R3 in place",
          int'(rsp_phys), ep);
    if (!eerr && need_new) check(lat >= ERASE, "R6 erase latency", lat, ERASE);
    if (!need_new) check(lat < ERASE, "R6 R3 no erase", lat, ERASE);
    after_rsp();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++) cnt[b] = 0;
    for (int g = 0; g < NG; g++) begin bound[g] = 0; gblk[g] = 0; end
    for (int l = 0; l < LP; l++) begin valid[l] = 0; data[l] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
    check(rsp_valid == 1'b0, "R1 no rsp", int'(rsp_valid), 0);
    read_all("R2");
    do_write(0, 8'h11);
    do_write(1, 8'h22);
    read_all("R4");
    do_write(0, 8'h33);          // rewrite with a neighbour valid and two slots empty
    read_all("R5");
    for (int l = 2; l < LP; l++) do_write(l, 8'h40 + l);
    read_all("R4");
    for (int k = 0; k < 16; k++) begin
      do_write((k * 3) % LP, 8'hA0 + k);
      read_all("R5");
    end
    check(err_seen == 1'b1, "R8 R9 blocks exhausted", int'(err_seen), 1);
    do_write(5, 8'h5A);
    read_all("R9");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule